// File: doc/BRIEF.md
# AC97 Codec Register Command and Status Path

This block carries host accesses to the control registers of an AC97 codec. The host writes one command word holding a register index, a read/write flag and sixteen bits of write data. Any write with at least one byte lane enabled queues the command and raises a send-busy flag. When the link framer next opens a frame, the block marks slots 1 and 2 as valid in the outgoing tag and drives the formatted slot 1 and slot 2 fields. The busy flag drops when the framer reports that slot 2 of that frame has gone out.

On the receive side, the block watches slot 2 of each incoming frame. A slot 2 word is captured only when the incoming tag flags slot 2 as valid. A capture raises a data-valid flag. A capture made while that flag is still set also raises an overrun flag, and the older word is lost. A host read of the data register clears both flags. Serialization and the audio slots belong to neighbouring blocks.

Top module: `codec_regcmd`

## Requirements
- R1: After reset, all four status bits are 0, both transmit tag bits are 0, and both transmit slot fields are 0.
- R2: A write with cmd_wr=1 and any nonzero cmd_be, made while status bit 0 (send-busy) is 0, sets send-busy on the next clock. A write with cmd_be=0 changes nothing.
- R3: An accepted write updates only the command-word bytes whose cmd_be bit is set. The other bytes keep their previous contents. Byte 0 is data[7:0], byte 1 is data[15:8], and byte 2 is {read flag in bit 23, register index in bits 22:16}.
- R4: At the first frame_start after an accepted write, tx_tag_s1 and tx_tag_s2 both become 1. At the same clock, tx_slot1 becomes {flag, index, 12 zero bits} and tx_slot2 becomes {data, 4 zero bits}. Outside a command frame, both slot fields read 0.
- R5: slot2_done during a command frame clears send-busy and both tag bits on the next clock. slot2_done outside a command frame has no effect.
- R6: A nonzero-enable write made while send-busy is 1 leaves the command word unchanged and sets status bit 3 (collision). A stat_rd pulse clears collision, unless a new collision arises in the same cycle.
- R7: A pulse on rx_slot2_stb with rx_tag_s2=1 loads rd_data and sets status bit 1 (data-valid). With rx_tag_s2=0, the pulse is ignored.
- R8: An accepted slot 2 word that arrives while data-valid is 1, with no data read in that cycle, sets status bit 2 (overrun) and replaces rd_data.
- R9: data_rd clears data-valid and overrun. If a slot 2 word is accepted in the same cycle, the new word is loaded, data-valid ends as 1 and overrun ends as 0.
- R10: A write made in the same cycle as frame_start does not ride that frame. It goes out at the following frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_be | input | 3 | Byte enables of the command write |
| cmd_wdata | input | 24 | Command write data: flag, index, write data |
| data_rd | input | 1 | Read strobe of the received data register |
| stat_rd | input | 1 | Status read strobe; clears collision |
| rd_data | output | 16 | Last received slot 2 word |
| status | output | 4 | {collision, overrun, data-valid, send-busy} |
| frame_start | input | 1 | Framer pulse at the opening of each transmit frame |
| slot2_done | input | 1 | Framer pulse after transmit slot 2 is shifted out |
| tx_tag_s1 | output | 1 | Slot 1 valid bit for the outgoing tag |
| tx_tag_s2 | output | 1 | Slot 2 valid bit for the outgoing tag |
| tx_slot1 | output | 20 | Outgoing slot 1 field |
| tx_slot2 | output | 20 | Outgoing slot 2 field |
| rx_slot2_stb | input | 1 | Pulse when an incoming slot 2 word is present |
| rx_tag_s2 | input | 1 | Slot 2 valid bit of the incoming tag |
| rx_slot2 | input | 16 | Upper 16 bits of the incoming slot 2 |

## Verification
Two kinds of event can meet in one clock cycle.

On the receive side, a host data read can coincide with a tagged slot 2 arrival. The bench provokes this inside a sweep of strobe, tag and read combinations, and a cycle-level model decides each outcome: the new word must be kept, data-valid must stay set and overrun must be clear.

On the transmit side, a host write can coincide with the framer's slot2_done or frame_start, and a collision can coincide with a status read. Each of these cases is driven directly, and the result is judged on the busy and collision bits and on which command word appears in the slots.

// File: rtl/codec_rc_pkg.sv
package codec_rc_pkg;
   typedef struct packed {
      logic coll;
      logic ovr;
      logic valid;
      logic busy;
   } rc_status_t;
endpackage

// File: rtl/codec_cmd_tx.sv
module codec_cmd_tx #(
   parameter int IDX_W      = 7,
   parameter int DATA_W     = 16,
   parameter int SLOT_W     = 20,
   parameter bit BYTE_MERGE = 1'b1,
   localparam int CMD_W     = 1 + IDX_W + DATA_W,
   localparam int NB        = CMD_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [NB-1:0]     cmd_be,
   input  logic [CMD_W-1:0]  cmd_wdata,
   input  logic              stat_rd,
   input  logic              frame_start,
   input  logic              slot2_done,
   output logic              busy_o,
   output logic              coll_o,
   output logic              tag_o,
   output logic [SLOT_W-1:0] slot1_o,
   output logic [SLOT_W-1:0] slot2_o
);
   localparam int RW_BIT = CMD_W - 1;
   localparam int S1_SH  = SLOT_W - 1 - IDX_W;
   localparam int S2_SH  = SLOT_W - DATA_W;

   if (CMD_W % 8 != 0) begin : g_bad_bytes
      $error("command word must be a whole number of bytes");
   end
   if (SLOT_W < DATA_W || SLOT_W < 1 + IDX_W) begin : g_bad_slot
      $error("slot too narrow for command fields");
   end

   logic [CMD_W-1:0] cmd_q, cmd_next;
   logic busy_q, pend_q, act_q, coll_q;
   logic wr_hit, accept;

   if (BYTE_MERGE) begin : g_merge
      for (genvar b = 0; b < NB; b++) begin : g_lane
         assign cmd_next[8*b +: 8] = cmd_be[b] ? cmd_wdata[8*b +: 8] : cmd_q[8*b +: 8];
      end
   end else begin : g_whole
      assign cmd_next = cmd_wdata;
   end

   assign wr_hit = cmd_wr && (|cmd_be);
   assign accept = wr_hit && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         busy_q <= 1'b0;
         pend_q <= 1'b0;
         act_q  <= 1'b0;
         coll_q <= 1'b0;
      end else begin
         if (accept) begin
            cmd_q  <= cmd_next;
            busy_q <= 1'b1;
            pend_q <= 1'b1;
         end else if (act_q && slot2_done) begin
            busy_q <= 1'b0;
         end
         if (frame_start && pend_q) begin
            act_q  <= 1'b1;
            pend_q <= 1'b0;
         end else if (act_q && slot2_done) begin
            act_q <= 1'b0;
         end
         if (wr_hit && busy_q)
            coll_q <= 1'b1;
         else if (stat_rd)
            coll_q <= 1'b0;
      end
   end

   assign busy_o  = busy_q;
   assign coll_o  = coll_q;
   assign tag_o   = act_q;
   assign slot1_o = act_q ? (SLOT_W'(cmd_q[RW_BIT -: 1 + IDX_W]) << S1_SH) : '0;
   assign slot2_o = act_q ? (SLOT_W'(cmd_q[DATA_W-1:0]) << S2_SH) : '0;

   assert_busy_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !busy_q) |=> busy_q);
   assert_ignored_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && busy_q) |=> ($stable(cmd_q) && coll_q));
   assert_active_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      act_q |-> busy_q);
   assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && slot2_done) |=> (!busy_q && !act_q));
   assert_late_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && frame_start) |=> !act_q);
endmodule

// File: rtl/codec_stat_rx.sv
module codec_stat_rx #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_stb,
   input  logic              rx_tag_ok,
   input  logic [DATA_W-1:0] rx_word,
   input  logic              data_rd,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o,
   output logic              ovr_o
);
   if (DATA_W < 1) begin : g_bad_w
      $error("data width must be positive");
   end

   logic [DATA_W-1:0] data_q;
   logic valid_q, ovr_q, take;

   assign take = rx_stb && rx_tag_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         valid_q <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         if (take) begin
            data_q  <= rx_word;
            valid_q <= 1'b1;
            ovr_q   <= (valid_q || ovr_q) && !data_rd;
         end else if (data_rd) begin
            valid_q <= 1'b0;
            ovr_q   <= 1'b0;
         end
      end
   end

   assign data_o  = data_q;
   assign valid_o = valid_q;
   assign ovr_o   = ovr_q;

   assert_ovr_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q |-> valid_q);
   assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !data_rd) |=> ($stable(data_q) && $stable(valid_q)));
   assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !take) |=> (!valid_q && !ovr_q));
   assert_read_and_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && take) |=> (valid_q && !ovr_q));
endmodule

// File: rtl/codec_regcmd.sv
module codec_regcmd #(
   parameter int IDX_W      = 7,
   parameter int DATA_W     = 16,
   parameter int SLOT_W     = 20,
   parameter bit BYTE_MERGE = 1'b1,
   localparam int CMD_W     = 1 + IDX_W + DATA_W,
   localparam int NB        = CMD_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [NB-1:0]     cmd_be,
   input  logic [CMD_W-1:0]  cmd_wdata,
   input  logic              data_rd,
   input  logic              stat_rd,
   output logic [DATA_W-1:0] rd_data,
   output logic [3:0]        status,
   input  logic              frame_start,
   input  logic              slot2_done,
   output logic              tx_tag_s1,
   output logic              tx_tag_s2,
   output logic [SLOT_W-1:0] tx_slot1,
   output logic [SLOT_W-1:0] tx_slot2,
   input  logic              rx_slot2_stb,
   input  logic              rx_tag_s2,
   input  logic [DATA_W-1:0] rx_slot2
);
   import codec_rc_pkg::*;

   rc_status_t st;
   logic tag;

   codec_cmd_tx #(
      .IDX_W(IDX_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W), .BYTE_MERGE(BYTE_MERGE)
   ) u_tx (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_be(cmd_be),
      .cmd_wdata(cmd_wdata), .stat_rd(stat_rd), .frame_start(frame_start),
      .slot2_done(slot2_done), .busy_o(st.busy), .coll_o(st.coll),
      .tag_o(tag), .slot1_o(tx_slot1), .slot2_o(tx_slot2)
   );

   codec_stat_rx #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_stb(rx_slot2_stb), .rx_tag_ok(rx_tag_s2),
      .rx_word(rx_slot2), .data_rd(data_rd), .data_o(rd_data),
      .valid_o(st.valid), .ovr_o(st.ovr)
   );

   assign tx_tag_s1 = tag;
   assign tx_tag_s2 = tag;
   assign status    = st;
endmodule

// File: tb/codec_regcmd_tb.sv
module codec_regcmd_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_wr = 0, data_rd = 0, stat_rd = 0, frame_start = 0, slot2_done = 0;
   logic rx_slot2_stb = 0, rx_tag_s2 = 0;
   logic [2:0] cmd_be = '0;
   logic [23:0] cmd_wdata = '0;
   logic [15:0] rx_slot2 = '0;
   logic [15:0] rd_data;
   logic [3:0] status;
   logic tx_tag_s1, tx_tag_s2;
   logic [19:0] tx_slot1, tx_slot2;

   int n_chk = 0, n_err = 0;
   logic [23:0] mreg = '0;
   logic m_valid = 0, m_ovr = 0;
   logic [15:0] m_data = '0;

   always #2 clk = ~clk;

   codec_regcmd u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_be(cmd_be),
      .cmd_wdata(cmd_wdata), .data_rd(data_rd), .stat_rd(stat_rd),
      .rd_data(rd_data), .status(status), .frame_start(frame_start),
      .slot2_done(slot2_done), .tx_tag_s1(tx_tag_s1), .tx_tag_s2(tx_tag_s2),
      .tx_slot1(tx_slot1), .tx_slot2(tx_slot2), .rx_slot2_stb(rx_slot2_stb),
      .rx_tag_s2(rx_tag_s2), .rx_slot2(rx_slot2)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One cycle of stimulus; returns at the next falling edge with inputs idle.
   task automatic step(input logic wr, input logic [2:0] be, input logic [23:0] wd,
                       input logic fs, input logic s2d, input logic drd, input logic srd,
                       input logic stb, input logic tg, input logic [15:0] rw);
      cmd_wr = wr; cmd_be = be; cmd_wdata = wd; frame_start = fs; slot2_done = s2d;
      data_rd = drd; stat_rd = srd; rx_slot2_stb = stb; rx_tag_s2 = tg; rx_slot2 = rw;
      @(negedge clk);
      cmd_wr = 0; cmd_be = '0; frame_start = 0; slot2_done = 0;
      data_rd = 0; stat_rd = 0; rx_slot2_stb = 0; rx_tag_s2 = 0;
   endtask

   task automatic chk_slots(input string req, input logic on);
      chk(req, {30'd0, tx_tag_s1, tx_tag_s2}, on ? 32'd3 : 32'd0);
      chk(req, 32'(tx_slot1), on ? 32'({mreg[23], mreg[22:16], 12'h000}) : 32'd0);
      chk(req, 32'(tx_slot2), on ? 32'({mreg[15:0], 4'h0}) : 32'd0);
   endtask

   task automatic rx_step(input logic stb, input logic tg, input logic rd, input logic [15:0] w);
      logic take;
      take = stb && tg;
      step(0, '0, '0, 0, 0, rd, 0, stb, tg, w);
      if (take) begin
         m_ovr = (m_valid || m_ovr) && !rd;
         m_valid = 1'b1;
         m_data = w;
      end else if (rd) begin
         m_valid = 1'b0;
         m_ovr = 1'b0;
      end
   endtask

   task automatic chk_rx(input string req);
      chk(req, {30'd0, status[2], status[1]}, {30'd0, m_ovr, m_valid});
      chk(req, 32'(rd_data), 32'(m_data));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 status", 32'(status), 32'd0);
      chk_slots("R1 slots", 1'b0);

      // R2 R3 R4 R5 sweep over all byte-enable patterns
      for (int be = 0; be < 8; be++) begin
         logic [23:0] d;
         d = 24'h9C35E1 ^ (24'(be) * 24'h2B1D07);
         step(1, 3'(be), d, 0, 0, 0, 0, 0, 0, '0);
         for (int k = 0; k < 3; k++)
            if (be[k]) mreg[8*k +: 8] = d[8*k +: 8];
         chk("R2 busy after write", 32'(status[0]), (be != 0) ? 32'd1 : 32'd0);
         step(0, '0, '0, 1, 0, 0, 0, 0, 0, '0);
         chk_slots("R3 R4 command frame", be != 0);
         step(0, '0, '0, 0, 1, 0, 0, 0, 0, '0);
         chk("R5 busy cleared", 32'(status[0]), 32'd0);
         chk_slots("R5 tag dropped", 1'b0);
      end

      // R6 collision
      step(1, 3'h7, 24'hA1B2C3, 0, 0, 0, 0, 0, 0, '0);
      mreg = 24'hA1B2C3;
      step(1, 3'h7, 24'h0F0F0F, 0, 0, 0, 0, 0, 0, '0);
      chk("R6 collision set", 32'(status[3]), 32'd1);
      chk("R6 still busy", 32'(status[0]), 32'd1);
      step(0, '0, '0, 1, 0, 0, 0, 0, 0, '0);
      chk_slots("R6 first command kept", 1'b1);
      step(0, '0, '0, 0, 0, 0, 1, 0, 0, '0);
      chk("R6 stat_rd clears", 32'(status[3]), 32'd0);
      step(1, 3'h7, 24'h123456, 0, 1, 0, 0, 0, 0, '0);
      chk("R6 write at done ignored", 32'(status[3:0]), 32'h8);
      step(0, '0, '0, 1, 0, 0, 0, 0, 0, '0);
      chk_slots("R6 no stale send", 1'b0);
      step(0, '0, '0, 0, 0, 0, 1, 0, 0, '0);

      // R6 collision and stat_rd together
      step(1, 3'h7, 24'h00FFEE, 0, 0, 0, 0, 0, 0, '0);
      mreg = 24'h00FFEE;
      step(1, 3'h7, 24'h777777, 0, 0, 0, 1, 0, 0, '0);
      chk("R6 set beats clear", 32'(status[3]), 32'd1);
      step(0, '0, '0, 1, 0, 0, 0, 0, 0, '0);
      chk_slots("R6 kept word", 1'b1);
      step(0, '0, '0, 0, 1, 0, 1, 0, 0, '0);
      chk("R6 cleared idle", 32'(status[3:0]), 32'd0);

      // R10 write together with frame_start
      step(1, 3'h7, 24'hD00D5A, 1, 0, 0, 0, 0, 0, '0);
      mreg = 24'hD00D5A;
      chk("R10 busy", 32'(status[0]), 32'd1);
      chk_slots("R10 not this frame", 1'b0);
      step(0, '0, '0, 0, 1, 0, 0, 0, 0, '0);
      chk("R5 done outside frame", 32'(status[0]), 32'd1);
      step(0, '0, '0, 1, 0, 0, 0, 0, 0, '0);
      chk_slots("R10 next frame", 1'b1);
      step(0, '0, '0, 0, 1, 0, 0, 0, 0, '0);

      // R7 R8 R9 directed
      rx_step(1, 0, 0, 16'hBEEF);
      chk_rx("R7 untagged ignored");
      rx_step(1, 1, 0, 16'h1357);
      chk_rx("R7 tagged capture");
      rx_step(1, 1, 0, 16'h2468);
      chk_rx("R8 overrun");
      chk("R8 ovr bit", 32'(status[2]), 32'd1);
      rx_step(1, 1, 1, 16'hACE1);
      chk_rx("R9 read with arrival");
      chk("R9 valid kept", 32'(status[2:1]), 32'b01);
      rx_step(0, 0, 1, 16'h0);
      chk_rx("R9 read clears");
      chk("R9 flags clear", 32'(status[2:1]), 32'd0);

      // R7 R8 R9 sweep
      for (int i = 0; i < 60; i++) begin
         logic stb, tg, rd;
         stb = (i % 3) != 2;
         tg  = (i % 5) != 4;
         rd  = (i % 4) == 3;
         rx_step(stb, tg, rd, 16'(i * 16'h0B3D + 16'h1111));
         chk_rx("R7 R8 R9 sweep");
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule